// File: doc/BRIEF.md
# Hardware Return Address Stack

This block holds the return addresses of a small microcontroller core. Program counter values (21 bits by default) are kept in a 32-location array, and a 5-bit stack pointer selects the current top of stack. Calls, interrupt entry and an explicit push instruction all share one push request. Returns and an explicit pop instruction share one pop request. The top-of-stack entry is always visible on `tos_pc`. During a pop cycle, that value is the return address handed back to the pipeline. Location 0 never holds data, so a pop from an empty stack returns zero and sends the program to the reset vector.

Software reaches the block through a single byte-wide write port. It can write the stack pointer, each of the three top-of-stack byte fields, and the two sticky status flags. The values are read back on the output ports. The overflow and underflow policy depends on a configuration input. With the input set to 1, an overflowing push or an underflowing pop raises a one-cycle reset request, and an overflow also forces the pointer to zero. With the input set to 0, the pointer saturates at the top location and later pushes overwrite that entry.

The pointer logic is a state machine with three named states. `ST_EMPTY` means the pointer is 0. `ST_FILLING` means the pointer is between 1 and DEPTH-2. `ST_FULL` means the pointer is DEPTH-1. The transitions are:
- *fill_first*: a push in `ST_EMPTY` moves to `ST_FILLING`.
- *fill_step*: a push or pop in `ST_FILLING` stays there unless it reaches an edge.
- *fill_top*: a push in `ST_FILLING` from pointer DEPTH-2 moves to `ST_FULL`.
- *drain_last*: a pop in `ST_FILLING` from pointer 1 moves to `ST_EMPTY`.
- *drain_top*: a pop in `ST_FULL` moves to `ST_FILLING`.
- *ovf_wrap*: an overflowing push in `ST_FULL` with the reset request enabled moves to `ST_EMPTY`.
- *ovf_hold*: an overflowing push in `ST_FULL` with the reset request disabled stays in `ST_FULL`.
- *unf_hold*: a pop in `ST_EMPTY` stays in `ST_EMPTY`.
- *sw_load*: a software pointer write moves to whichever state matches the written pointer.

Top module: `ret_stack_top`

## Requirements
- R1: After reset the pointer is 0, `tos_pc` is 0, and both flags and `rst_req` are 0.
- R2: Whenever the pointer is 0, `tos_pc` reads 0. A software byte write to the top of stack while the pointer is 0 has no effect.
- R3: A push below the top location increments the pointer and stores `push_pc` at the new pointer, so `tos_pc` equals `push_pc` after the edge.
- R4: A pop at a nonzero pointer decrements the pointer, so `tos_pc` shows the previously pushed value.
- R5: A push at pointer 31 with `cfg_ovf_rst_en`=1 sets the overflow flag, forces the pointer to 0 and raises `rst_req`.
- R6: A push at pointer 31 with `cfg_ovf_rst_en`=0 sets the overflow flag, keeps the pointer at 31, overwrites location 31 with `push_pc` and raises no `rst_req`.
- R7: A pop at pointer 0 presents 0 on `tos_pc` in that cycle, sets the underflow flag and leaves the pointer at 0. It raises `rst_req` only when `cfg_ovf_rst_en`=1.
- R8: `rst_req` is high for exactly the one cycle after the edge that processed the triggering push or pop.
- R9: The flags are sticky. A software write with `sw_sel`=4 loads overflow from `sw_wdata[0]` and underflow from `sw_wdata[1]`, and this write never raises `rst_req`.
- R10: Software top-of-stack byte writes act on the entry at the pointer. `sw_sel`=1 writes bits 7:0, `sw_sel`=2 writes bits 15:8, and `sw_sel`=3 writes bits 20:16 from `sw_wdata[4:0]`. Each write leaves the other bits unchanged.
- R11: A software write with `sw_sel`=0 loads the pointer from `sw_wdata[4:0]` at the next edge.
- R12: A push or pop in the same cycle as a software write takes effect and the software write is dropped. When push and pop are requested together, the push is performed and the pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_ovf_rst_en | input | 1 | 1: overflow/underflow requests a reset; 0: saturate |
| push_req | input | 1 | Push request (call, interrupt, explicit push) |
| push_pc | input | 21 | Program counter value to push |
| pop_req | input | 1 | Pop request (return, explicit pop) |
| sw_wr_en | input | 1 | Software write strobe |
| sw_sel | input | 3 | Write target: 0 pointer, 1 TOS low, 2 TOS high, 3 TOS upper, 4 flags |
| sw_wdata | input | 8 | Software write data |
| stk_ptr | output | 5 | Current stack pointer |
| tos_pc | output | 21 | Top-of-stack entry (return address during a pop) |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest condition to reach from the ports is saturated overflow with stale contents beneath it. The pointer has to reach 31 through real pushes. Location 31 then has to be overwritten more than once, and a following pop must expose the untouched entry at location 30. The bench gets there by first filling the stack with reset enabled, letting the overflow wrap the pointer to zero, and then refilling with different values. Each overwrite and the later pop can then be told apart from leftovers of the first fill.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_FILLING = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_e;

    localparam logic [2:0] SEL_PTR    = 3'd0;
    localparam logic [2:0] SEL_TOS_LO = 3'd1;
    localparam logic [2:0] SEL_TOS_HI = 3'd2;
    localparam logic [2:0] SEL_TOS_UP = 3'd3;
    localparam logic [2:0] SEL_FLAGS  = 3'd4;

endpackage

// File: rtl/ras_store.sv
module ras_store #(
    parameter int PC_W  = 21,
    parameter int DEPTH = 32,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [PC_W-1:0]  wr_data,
    input  logic [PC_W-1:0]  wr_mask,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [PC_W-1:0]  rd_data
);

    logic [PC_W-1:0] ent [DEPTH];

    // Location 0 holds no data and always reads as zero.
    assign ent[0] = '0;

    for (genvar g = 1; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent[g] <= '0;
            end else if (wr_en && (wr_addr == PTR_W'(g))) begin
                ent[g] <= (ent[g] & ~wr_mask) | (wr_data & wr_mask);
            end
        end
    end

    assign rd_data = ent[rd_addr];

endmodule

// File: rtl/ras_ptr_fsm.sv
module ras_ptr_fsm
    import ras_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_rst_en,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             sw_wr_en,
    input  logic [2:0]       sw_sel,
    input  logic [7:0]       sw_wdata,
    output logic [PTR_W-1:0] ptr,
    output logic             ovf,
    output logic             unf,
    output logic             rst_req,
    output logic             push_we,
    output logic [PTR_W-1:0] push_addr,
    output logic             sw_take
);

    localparam logic [PTR_W-1:0] TOP = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    fill_state_e      state_q, state_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             ovf_q, ovf_d, unf_q, unf_d, req_q, req_d;
    logic             do_push, do_pop;

    function automatic fill_state_e classify(input logic [PTR_W-1:0] p);
        if (p == '0)       return ST_EMPTY;
        else if (p == TOP) return ST_FULL;
        else               return ST_FILLING;
    endfunction

    assign do_push = push_req;
    assign do_pop  = pop_req && !push_req;
    assign sw_take = sw_wr_en && !push_req && !pop_req;

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            ptr_q   <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            ovf_q   <= ovf_d;
            unf_q   <= unf_d;
            req_q   <= req_d;
        end
    end

    // Next-state and output process.
    always_comb begin
        state_d   = state_q;
        ptr_d     = ptr_q;
        ovf_d     = ovf_q;
        unf_d     = unf_q;
        req_d     = 1'b0;
        push_we   = 1'b0;
        push_addr = ptr_q + ONE;
        unique case (state_q)
            ST_EMPTY: begin
                if (do_push) begin                 // fill_first
                    ptr_d   = ONE;
                    push_we = 1'b1;
                    state_d = classify(ONE);
                end else if (do_pop) begin         // unf_hold
                    unf_d = 1'b1;
                    req_d = cfg_rst_en;
                end
            end
            ST_FILLING: begin
                if (do_push) begin                 // fill_step / fill_top
                    ptr_d   = ptr_q + ONE;
                    push_we = 1'b1;
                    state_d = classify(ptr_q + ONE);
                end else if (do_pop) begin         // fill_step / drain_last
                    ptr_d   = ptr_q - ONE;
                    state_d = classify(ptr_q - ONE);
                end
            end
            ST_FULL: begin
                if (do_push) begin
                    ovf_d = 1'b1;
                    if (cfg_rst_en) begin          // ovf_wrap
                        req_d   = 1'b1;
                        ptr_d   = '0;
                        state_d = ST_EMPTY;
                    end else begin                 // ovf_hold
                        push_we   = 1'b1;
                        push_addr = TOP;
                    end
                end else if (do_pop) begin         // drain_top
                    ptr_d   = TOP - ONE;
                    state_d = classify(TOP - ONE);
                end
            end
            default: begin
                state_d = ST_EMPTY;
                ptr_d   = '0;
            end
        endcase
        if (sw_take) begin
            if (sw_sel == SEL_PTR) begin           // sw_load
                ptr_d   = sw_wdata[PTR_W-1:0];
                state_d = classify(sw_wdata[PTR_W-1:0]);
            end else if (sw_sel == SEL_FLAGS) begin
                ovf_d = sw_wdata[0];
                unf_d = sw_wdata[1];
            end
        end
    end

    assign ptr     = ptr_q;
    assign ovf     = ovf_q;
    assign unf     = unf_q;
    assign rst_req = req_q;

endmodule

// File: rtl/ret_stack_top.sv
module ret_stack_top
    import ras_pkg::*;
#(
    parameter int PC_W  = 21,
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_ovf_rst_en,
    input  logic                     push_req,
    input  logic [PC_W-1:0]          push_pc,
    input  logic                     pop_req,
    input  logic                     sw_wr_en,
    input  logic [2:0]               sw_sel,
    input  logic [7:0]               sw_wdata,
    output logic [$clog2(DEPTH)-1:0] stk_ptr,
    output logic [PC_W-1:0]          tos_pc,
    output logic                     ovf_flag,
    output logic                     unf_flag,
    output logic                     rst_req
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int UP_W  = PC_W - 16;

    logic             push_we, sw_take;
    logic [PTR_W-1:0] push_addr, ptr;
    logic             st_we;
    logic [PTR_W-1:0] st_addr;
    logic [PC_W-1:0]  st_data, st_mask;

    ras_ptr_fsm #(.DEPTH(DEPTH), .PTR_W(PTR_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_rst_en(cfg_ovf_rst_en),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .sw_wr_en  (sw_wr_en),
        .sw_sel    (sw_sel),
        .sw_wdata  (sw_wdata),
        .ptr       (ptr),
        .ovf       (ovf_flag),
        .unf       (unf_flag),
        .rst_req   (rst_req),
        .push_we   (push_we),
        .push_addr (push_addr),
        .sw_take   (sw_take)
    );

    // Store write port: a push owns it; otherwise a software byte write.
    always_comb begin
        st_we   = 1'b0;
        st_addr = ptr;
        st_data = '0;
        st_mask = '0;
        if (push_we) begin
            st_we   = 1'b1;
            st_addr = push_addr;
            st_data = push_pc;
            st_mask = '1;
        end else if (sw_take && ptr != '0) begin
            if (sw_sel == SEL_TOS_LO) begin
                st_we        = 1'b1;
                st_data[7:0] = sw_wdata;
                st_mask[7:0] = '1;
            end else if (sw_sel == SEL_TOS_HI) begin
                st_we         = 1'b1;
                st_data[15:8] = sw_wdata;
                st_mask[15:8] = '1;
            end else if (sw_sel == SEL_TOS_UP) begin
                st_we             = 1'b1;
                st_data[PC_W-1:16] = sw_wdata[UP_W-1:0];
                st_mask[PC_W-1:16] = '1;
            end
        end
    end

    ras_store #(.PC_W(PC_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (st_we),
        .wr_addr(st_addr),
        .wr_data(st_data),
        .wr_mask(st_mask),
        .rd_addr(ptr),
        .rd_data(tos_pc)
    );

    assign stk_ptr = ptr;

endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
    parameter int PC_W  = 21,
    parameter int DEPTH = 32,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_ovf_rst_en,
    input logic             push_req,
    input logic [PC_W-1:0]  push_pc,
    input logic             pop_req,
    input logic             sw_wr_en,
    input logic [2:0]       sw_sel,
    input logic [PTR_W-1:0] stk_ptr,
    input logic [PC_W-1:0]  tos_pc,
    input logic             ovf_flag,
    input logic             unf_flag,
    input logic             rst_req
);

    localparam logic [PTR_W-1:0] TOP = PTR_W'(DEPTH - 1);

    a_r2_zero_tos: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ptr == '0 |-> tos_pc == '0);

    a_r3_push_incr: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && stk_ptr != TOP |=>
            stk_ptr == $past(stk_ptr) + PTR_W'(1) && tos_pc == $past(push_pc));

    a_r4_pop_decr: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !push_req && stk_ptr != '0 |=>
            stk_ptr == $past(stk_ptr) - PTR_W'(1));

    a_r5_ovf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && stk_ptr == TOP && cfg_ovf_rst_en |=>
            stk_ptr == '0 && ovf_flag && rst_req);

    a_r6_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && stk_ptr == TOP && !cfg_ovf_rst_en |=>
            stk_ptr == TOP && ovf_flag && !rst_req && tos_pc == $past(push_pc));

    a_r7_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !push_req && stk_ptr == '0 |=>
            stk_ptr == '0 && unf_flag && rst_req == $past(cfg_ovf_rst_en));

    a_r9_sw_no_rst: assert property (@(posedge clk) disable iff (!rst_n)
        !push_req && !pop_req |=> !rst_req);

endmodule

bind ret_stack_top ret_stack_chk #(.PC_W(PC_W), .DEPTH(DEPTH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_ovf_rst_en(cfg_ovf_rst_en),
    .push_req      (push_req),
    .push_pc       (push_pc),
    .pop_req       (pop_req),
    .sw_wr_en      (sw_wr_en),
    .sw_sel        (sw_sel),
    .stk_ptr       (stk_ptr),
    .tos_pc        (tos_pc),
    .ovf_flag      (ovf_flag),
    .unf_flag      (unf_flag),
    .rst_req       (rst_req)
);

// File: tb/ret_stack_top_tb_top.sv
module ret_stack_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg = 1'b1;
    logic        push_req = 1'b0;
    logic [20:0] push_pc = '0;
    logic        pop_req = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [2:0]  sw_sel = '0;
    logic [7:0]  sw_wdata = '0;
    logic [4:0]  stk_ptr;
    logic [20:0] tos_pc;
    logic        ovf_flag, unf_flag, rst_req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ret_stack_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ovf_rst_en(cfg),
        .push_req(push_req), .push_pc(push_pc), .pop_req(pop_req),
        .sw_wr_en(sw_wr_en), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .stk_ptr(stk_ptr), .tos_pc(tos_pc), .ovf_flag(ovf_flag),
        .unf_flag(unf_flag), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Each operation: inputs driven after a negedge, sampled at the next negedge.
    task automatic op(input bit pu, input bit po, input logic [20:0] pc,
                      input bit sw, input logic [2:0] sel, input logic [7:0] d);
        push_req = pu; pop_req = po; push_pc = pc;
        sw_wr_en = sw; sw_sel = sel; sw_wdata = d;
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0; sw_wr_en = 1'b0;
    endtask

    task automatic push(input logic [20:0] pc); op(1, 0, pc, 0, 0, 0); endtask
    task automatic pop();                        op(0, 1, 0, 0, 0, 0); endtask
    task automatic swr(input logic [2:0] s, input logic [7:0] d); op(0, 0, 0, 1, s, d); endtask
    task automatic idle();                       op(0, 0, 0, 0, 0, 0); endtask

    task automatic t_reset();
        chk("R1 ptr", stk_ptr, 0);
        chk("R1 tos", tos_pc, 0);
        chk("R1 flags", {ovf_flag, unf_flag, rst_req}, 0);
    endtask

    task automatic t_push_pop();
        push(21'h0ABCDE);
        chk("R3 ptr", stk_ptr, 1);
        chk("R3 tos", tos_pc, 21'h0ABCDE);
        push(21'h1F0F0F);
        chk("R3 tos2", tos_pc, 21'h1F0F0F);
        pop();
        chk("R4 ptr", stk_ptr, 1);
        chk("R4 tos", tos_pc, 21'h0ABCDE);
    endtask

    task automatic t_sw_regs();
        swr(3'd1, 8'h55);
        chk("R10 low", tos_pc, 21'h0ABC55);
        swr(3'd2, 8'h12);
        chk("R10 high", tos_pc, 21'h0A1255);
        swr(3'd3, 8'hF3);
        chk("R10 upper", tos_pc, 21'h131255);
        swr(3'd0, 8'h00);
        chk("R11 ptr0", stk_ptr, 0);
        swr(3'd1, 8'hAA);
        chk("R2 tos at 0", tos_pc, 0);
        swr(3'd0, 8'h01);
        chk("R11 ptr1", stk_ptr, 1);
        chk("R2 entry1 kept", tos_pc, 21'h131255);
    endtask

    task automatic t_priority();
        op(1, 0, 21'h000777, 1, 3'd0, 8'h09);
        chk("R12 push over sw ptr", stk_ptr, 2);
        chk("R12 push data", tos_pc, 21'h000777);
        op(1, 1, 21'h000888, 0, 0, 0);
        chk("R12 push over pop", stk_ptr, 3);
        op(0, 1, 0, 1, 3'd1, 8'h33);
        chk("R12 pop over sw", stk_ptr, 2);
        chk("R12 sw byte dropped", tos_pc, 21'h000777);
    endtask

    task automatic t_ovf_wrap();
        cfg = 1'b1;
        swr(3'd0, 8'h00);
        for (int i = 1; i <= 31; i++) push(21'(i));
        chk("R3 fill ptr", stk_ptr, 31);
        chk("R3 fill tos", tos_pc, 31);
        push(21'h1FFFFF);
        chk("R5 ptr", stk_ptr, 0);
        chk("R5 ovf", ovf_flag, 1);
        chk("R8 pulse", rst_req, 1);
        idle();
        chk("R8 pulse ends", rst_req, 0);
        chk("R9 sticky", ovf_flag, 1);
        swr(3'd4, 8'h00);
        chk("R9 clear", ovf_flag, 0);
        swr(3'd4, 8'h01);
        chk("R9 sw set", ovf_flag, 1);
        chk("R9 no rst", rst_req, 0);
        swr(3'd4, 8'h00);
    endtask

    task automatic t_ovf_hold();
        cfg = 1'b0;
        for (int i = 1; i <= 31; i++) push(21'(100 + i));
        push(21'h0001F4);
        chk("R6 ptr", stk_ptr, 31);
        chk("R6 tos", tos_pc, 21'h0001F4);
        chk("R6 ovf", ovf_flag, 1);
        chk("R6 no rst", rst_req, 0);
        push(21'h0001F5);
        chk("R6 overwrite", tos_pc, 21'h0001F5);
        pop();
        chk("R4 below top", tos_pc, 130);
        swr(3'd4, 8'h00);
    endtask

    task automatic t_underflow();
        cfg = 1'b0;
        swr(3'd0, 8'h00);
        pop_req = 1'b1;
        #1;
        chk("R7 returns zero", tos_pc, 0);
        @(negedge clk);
        pop_req = 1'b0;
        chk("R7 unf", unf_flag, 1);
        chk("R7 ptr", stk_ptr, 0);
        chk("R7 no rst", rst_req, 0);
        cfg = 1'b1;
        pop();
        chk("R7 rst", rst_req, 1);
        swr(3'd4, 8'h00);
        chk("R9 unf clear", unf_flag, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_pop();
        t_sw_regs();
        t_priority();
        t_ovf_wrap();
        t_ovf_hold();
        t_underflow();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule